// File: doc/BRIEF.md
# Write-Once Fault Tristate Controller

This block decides, on every clock, whether each high-current timer output pin may drive or has to be released to high impedance. There are two timer units with three complementary output pairs each, which makes six pairs and twelve pins. Each pair has its own enable bit in a 16-bit control word. When a pair is enabled and any fault source is active, both pins of that pair lose their output enable. The fault sources are three external fault flags, a high-impedance request from the timer, and an output-short flag that counts only while its compare enable is set.

An enabled pair is also watched for a short risk, which is both of its pins driven to the active level at the same time. This indication goes out to the fault-flag logic elsewhere, which may turn it into the short flag. The control word can be loaded exactly once after power-on. A general reset clears the output-enable register but leaves the lock in place.

Top module: `fault_tristate_ctl`

## Requirements
- R1: After power-on reset (`por_n` low) the control word reads 0x7700, with all six pair enables at 1.
- R2: Bits 15, 11 and 7..0 of the control word always read 0, and writes to them have no effect.
- R3: The first write with `bus_be[1]`=1 (upper byte lane, bits 15..8) after power-on loads the pair enables from `bus_wdata`. Pair 0..2 take bits 14,13,12 and pair 3..5 take bits 10,9,8. A write with only `bus_be[0]` set changes nothing and does not lock.
- R4: After that first upper-byte write, later writes leave the enables unchanged until the next power-on reset. A general reset (`rst_n`) does not unlock them.
- R5: Pair p drives pins 2p and 2p+1. If its enable is 1 and any of `flt_ext[2:0]` or `flt_hiz_req` is 1, `pin_oe` of both pins is 0 from the next clock edge. `pin_oe`=1 means drive.
- R6: `short_flag` tristates enabled pairs only while `short_cmp_en` is 1.
- R7: A pair whose enable is 0 keeps `pin_oe`=11 whatever the fault inputs are.
- R8: `pin_oe` is registered. It is all ones during and after `rst_n` reset, it changes one clock after its condition, it stays low while a fault holds, and it returns to 1 one clock after the fault clears.
- R9: `short_risk[p]` is 1 exactly when pair p is enabled and both of its pins equal `ACTIVE_LEVEL` (default 1) in `pin_drv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears the lock |
| rst_n | input | 1 | General reset, active low, asynchronous; output-enable register only |
| bus_we | input | 1 | Write strobe for the control word |
| bus_be | input | 2 | Byte enables; bit 1 covers bits 15..8 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Control word read value |
| flt_ext | input | 3 | External-pin fault flags |
| flt_hiz_req | input | 1 | Timer high-impedance request |
| short_flag | input | 1 | Output-short fault flag |
| short_cmp_en | input | 1 | Enable for the short flag |
| pin_drv | input | 12 | Levels the timer drives on the pins |
| pin_oe | output | 12 | Per-pin output enable, 1 = drive |
| short_risk | output | 6 | Per-pair short-risk indication |

## Verification
The assertions check on every cycle that a locked control word never moves. They also check that an enabled pair under any fault loses both output enables on the next edge, that a disabled or fault-free pair keeps driving on the next edge, and that a short-risk indication is only raised for an enabled pair with both pins at the active level. Some behaviour can only be shown by the bench scenarios. That covers the power-on value, the masking of the reserved bits, the lower-lane write that must not lock, a general reset that must not unlock, and the one-cycle latency seen from both sides of a fault.

// File: rtl/fault_tristate_ctl.sv
`timescale 1ns/1ps
module fault_tristate_ctl #(
  parameter bit ACTIVE_LEVEL = 1'b1
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [1:0]  bus_be,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic [2:0]  flt_ext,
  input  logic        flt_hiz_req,
  input  logic        short_flag,
  input  logic        short_cmp_en,
  input  logic [11:0] pin_drv,
  output logic [11:0] pin_oe,
  output logic [5:0]  short_risk
);
  localparam int NPAIR = 6;
  localparam int NPIN  = 2 * NPAIR;

  logic [NPAIR-1:0] en_q;
  logic             locked;
  logic [NPAIR-1:0] en_wr;
  logic             upper_wr;
  logic             fault;
  logic [NPIN-1:0]  oe_d;
  logic             unused_bits;

  assign en_wr    = {bus_wdata[8], bus_wdata[9], bus_wdata[10],
                     bus_wdata[12], bus_wdata[13], bus_wdata[14]};
  assign upper_wr = bus_we & bus_be[1];
  assign unused_bits = ^{bus_wdata[15], bus_wdata[11], bus_wdata[7:0], bus_be[0]};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en_q   <= '1;
      locked <= 1'b0;
    end else if (upper_wr && !locked) begin
      en_q   <= en_wr;
      locked <= 1'b1;
    end
  end

  assign bus_rdata = {1'b0, en_q[0], en_q[1], en_q[2],
                      1'b0, en_q[3], en_q[4], en_q[5], 8'h00};

  assign fault = (|flt_ext) | flt_hiz_req | (short_flag & short_cmp_en);

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign oe_d[2*p+1:2*p] = {2{~(en_q[p] & fault)}};
    assign short_risk[p]   = en_q[p] & (pin_drv[2*p] == ACTIVE_LEVEL)
                                     & (pin_drv[2*p+1] == ACTIVE_LEVEL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_oe <= '1;
    else        pin_oe <= oe_d;
  end
endmodule

// File: rtl/fault_tristate_ctl_chk.sv
`timescale 1ns/1ps
module fault_tristate_ctl_chk #(
  parameter bit ACTIVE_LEVEL = 1'b1
) (
  input logic        clk,
  input logic        por_n,
  input logic        rst_n,
  input logic [15:0] bus_rdata,
  input logic [2:0]  flt_ext,
  input logic        flt_hiz_req,
  input logic        short_flag,
  input logic        short_cmp_en,
  input logic [11:0] pin_drv,
  input logic [11:0] pin_oe,
  input logic [5:0]  short_risk,
  input logic [5:0]  en_q,
  input logic        locked
);
  logic flt;
  assign flt = (|flt_ext) | flt_hiz_req | (short_flag & short_cmp_en);

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!por_n) locked |=> $stable(bus_rdata)); // R4

  for (genvar p = 0; p < 6; p++) begin : g_chk
    AST_PAIR_HIZ: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (flt && en_q[p]) |=> (pin_oe[2*p+1:2*p] == 2'b00)); // R5
    AST_PAIR_DRIVES: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (!flt || !en_q[p]) |=> (pin_oe[2*p+1:2*p] == 2'b11)); // R7
    AST_RISK_QUALIFIED: assert property (@(posedge clk) disable iff (!por_n)
      short_risk[p] |-> (en_q[p] && pin_drv[2*p] == ACTIVE_LEVEL && pin_drv[2*p+1] == ACTIVE_LEVEL)); // R9
  end
endmodule

bind fault_tristate_ctl fault_tristate_ctl_chk #(.ACTIVE_LEVEL(ACTIVE_LEVEL)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_rdata(bus_rdata),
  .flt_ext(flt_ext), .flt_hiz_req(flt_hiz_req), .short_flag(short_flag),
  .short_cmp_en(short_cmp_en), .pin_drv(pin_drv), .pin_oe(pin_oe),
  .short_risk(short_risk), .en_q(en_q), .locked(locked)
);

// File: tb/fault_tristate_ctl_bench.sv
`timescale 1ns/1ps
module fault_tristate_ctl_bench;
  logic        clk = 1'b0;
  logic        por_n, rst_n, bus_we;
  logic [1:0]  bus_be;
  logic [15:0] bus_wdata, bus_rdata;
  logic [2:0]  flt_ext;
  logic        flt_hiz_req, short_flag, short_cmp_en;
  logic [11:0] pin_drv, pin_oe;
  logic [5:0]  short_risk;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fault_tristate_ctl u_fault_tristate_ctl (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_we(bus_we), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flt_ext(flt_ext),
    .flt_hiz_req(flt_hiz_req), .short_flag(short_flag), .short_cmp_en(short_cmp_en),
    .pin_drv(pin_drv), .pin_oe(pin_oe), .short_risk(short_risk));

  function automatic logic [15:0] rd_of(input logic [5:0] en);
    return {1'b0, en[0], en[1], en[2], 1'b0, en[3], en[4], en[5], 8'h00};
  endfunction
  function automatic logic [11:0] oe_of(input logic [5:0] en, input logic f);
    logic [11:0] r;
    for (int p = 0; p < 6; p++) r[2*p +: 2] = (en[p] && f) ? 2'b00 : 2'b11;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk); bus_we = 1; bus_be = be; bus_wdata = d;
    @(negedge clk); bus_we = 0; bus_be = 0; bus_wdata = 0;
  endtask

  task automatic power_on;
    por_n = 0; rst_n = 0; bus_we = 0; bus_be = 0; bus_wdata = 0;
    flt_ext = 0; flt_hiz_req = 0; short_flag = 0; short_cmp_en = 0; pin_drv = 0;
    repeat (3) @(negedge clk);
    chk("R8 oe in reset", {4'h0, pin_oe}, 16'h0FFF);
    por_n = 1; rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset_value;
    chk("R1 reset value", bus_rdata, 16'h7700);
    chk("R8 oe after reset", {4'h0, pin_oe}, 16'h0FFF);
    chk("R9 no risk idle", {10'h0, short_risk}, 16'h0);
  endtask

  task automatic t_low_lane_write;
    wr(2'b01, 16'hFFFF);
    chk("R3 low lane no effect", bus_rdata, 16'h7700);
  endtask

  task automatic t_first_write(input logic [5:0] en);
    wr(2'b11, 16'hA5FF);
    chk("R3 first write loads", bus_rdata, rd_of(en));
    chk("R2 reserved read zero", bus_rdata & 16'h88FF, 16'h0);
    wr(2'b11, 16'h7700);
    chk("R4 second write ignored", bus_rdata, rd_of(en));
    wr(2'b10, 16'h0000);
    chk("R4 third write ignored", bus_rdata, rd_of(en));
  endtask

  task automatic t_fault(input logic [5:0] en, input int src);
    @(negedge clk);
    case (src)
      0, 1, 2: flt_ext[src] = 1;
      default: flt_hiz_req = 1;
    endcase
    #1 chk("R8 no change before edge", {4'h0, pin_oe}, {4'h0, oe_of(en, 0)});
    @(negedge clk);
    chk($sformatf("R5 fault src %0d", src), {4'h0, pin_oe}, {4'h0, oe_of(en, 1)});
    @(negedge clk);
    chk("R8 holds while fault", {4'h0, pin_oe}, {4'h0, oe_of(en, 1)});
    flt_ext = 0; flt_hiz_req = 0;
    @(negedge clk);
    chk("R8 release after fault", {4'h0, pin_oe}, {4'h0, oe_of(en, 0)});
  endtask

  task automatic t_short(input logic [5:0] en);
    @(negedge clk); short_flag = 1; short_cmp_en = 0;
    @(negedge clk);
    chk("R6 short without enable", {4'h0, pin_oe}, 16'h0FFF);
    short_cmp_en = 1;
    @(negedge clk);
    chk("R6 short with enable", {4'h0, pin_oe}, {4'h0, oe_of(en, 1)});
    short_flag = 0; short_cmp_en = 0;
    @(negedge clk);
  endtask

  task automatic t_risk(input logic [5:0] en);
    pin_drv = 12'hFFF; #1;
    chk("R9 risk both active", {10'h0, short_risk}, {10'h0, en});
    pin_drv = 12'h555; #1;
    chk("R9 risk one pin", {10'h0, short_risk}, 16'h0);
    pin_drv = 12'h000; #1;
    chk("R9 risk none active", {10'h0, short_risk}, 16'h0);
  endtask

  task automatic t_soft_reset(input logic [5:0] en);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R4 rst_n keeps value", bus_rdata, rd_of(en));
    wr(2'b11, 16'h7700);
    chk("R4 rst_n keeps lock", bus_rdata, rd_of(en));
  endtask

  task automatic t_disabled_all;
    wr(2'b11, 16'h0000);
    chk("R3 reload after por", bus_rdata, 16'h0000);
    @(negedge clk); flt_ext = 3'b111; flt_hiz_req = 1; short_flag = 1; short_cmp_en = 1;
    repeat (2) @(negedge clk);
    chk("R7 disabled pairs drive", {4'h0, pin_oe}, 16'h0FFF);
    flt_ext = 0; flt_hiz_req = 0; short_flag = 0; short_cmp_en = 0;
  endtask

  initial begin
    logic [5:0] en;
    en = 6'b101010;
    power_on;
    t_reset_value;
    t_low_lane_write;
    t_first_write(en);
    for (int s = 0; s < 4; s++) t_fault(en, s);
    t_short(en);
    t_risk(en);
    t_soft_reset(en);
    power_on;
    t_reset_value;
    t_fault(6'h3F, 1);
    t_disabled_all;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule